// File: doc/BRIEF.md
# Partitioned Subword SIMD ALU

This block adds or subtracts two 64-bit words that are each treated as a packed vector of equal-width lanes. Every lane is computed in parallel. A run-time select sets the lane width to 8, 16 or 32 bits. The carry chain is built from 8-bit slices, and the chain is cut wherever a lane begins, so no carry or borrow passes from one lane into the next.

Each operation runs in one of two arithmetic modes:

- **Wrapping:** the lane result is taken modulo 2^w.
- **Saturating:** a lane result that overflows is clamped to its limit.

In saturating mode the lanes are read as either unsigned or two's-complement signed numbers. A single output register holds the result. A valid/ready pair controls that register, so the block accepts one operation per clock and returns its result one cycle later.

Top module: `simd_alu`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is all zeros.
- R2: With sub_i=0 and sat_i=0, each lane of result_o is the sum of the matching lanes of a_i and b_i modulo 2^w. The lane width w is set by lane_sel_i: 2'b00 gives 8 bits, 2'b01 gives 16 bits and 2'b10 gives 32 bits. Lane 0 occupies the least significant bits.
- R3: With sub_i=1 and sat_i=0, each lane of result_o is a_i minus b_i in that lane, modulo 2^w.
- R4: No carry from an addition and no borrow from a subtraction crosses a lane boundary of the selected width.
- R5: With sat_i=1 and signed_i=0, lanes are unsigned. A sum above 2^w-1 gives all ones in that lane, and a difference below 0 gives 0.
- R6: With sat_i=1 and signed_i=1, lanes are two's complement. A result above 2^(w-1)-1 gives that value, and a result below -2^(w-1) gives -2^(w-1).
- R7: With sat_i=0, the value of signed_i has no effect on result_o.
- R8: lane_sel_i=2'b11 is reserved. An operation accepted with this code produces an all-zero result.
- R9: On a clock edge where ready_i=1, valid_o takes the value of valid_i. result_o loads the operation's result one cycle after an edge where both valid_i and ready_i are 1. When ready_i=0, result_o and valid_o hold their values.
- R10: ready_o always equals ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are valid |
| ready_o | output | 1 | Block can accept an operation |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| lane_sel_i | input | 2 | Lane width: 00=8, 01=16, 10=32, 11=reserved |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| sat_i | input | 1 | 0 = wrapping, 1 = saturating |
| signed_i | input | 1 | In saturating mode, 1 = signed lanes |
| valid_o | output | 1 | result_o holds a valid result |
| ready_i | input | 1 | Consumer accepts the result |
| result_o | output | 64 | Registered packed result |

## Verification
Two things happen in the same cycle: overflow out of one lane and arithmetic on its neighbour in the next higher lane. Saturation clamping and lane isolation must both act on that same carry.

The bench provokes this with operand bytes chosen from 0x00, 0x7F, 0x80 and 0xFF. These values make carries and borrows appear at every lane boundary for each lane width, while the adjacent lane computes its own result. Every lane of result_o is compared with a per-lane bench model that never lets a carry pass between lanes. A stalled ready_i is mixed in, so a new operation that arrives while the register holds must leave the held value unchanged.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int unsigned SLICE_W = 8;

  typedef enum logic [1:0] {
    LANE_8    = 2'b00,
    LANE_16   = 2'b01,
    LANE_32   = 2'b10,
    LANE_RSVD = 2'b11
  } lane_size_e;

  // slices per lane; 0 marks the reserved code
  function automatic int unsigned lane_span(lane_size_e sz);
    case (sz)
      LANE_8:  return 1;
      LANE_16: return 2;
      LANE_32: return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_ctl.sv
module simd_lane_ctl
  import simd_alu_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 8,
  parameter int unsigned IDX_W      = 3
) (
  input  lane_size_e             lane_size_i,
  output logic [NUM_SLICES-1:0]  first_o,
  output logic [NUM_SLICES-1:0]  last_o,
  output logic [IDX_W-1:0]       top_idx_o [NUM_SLICES],
  output logic                   lane_ok_o
);

  int unsigned span;

  always_comb begin
    span      = lane_span(lane_size_i);
    lane_ok_o = (span != 0);
    if (span == 0) span = 1;
    for (int unsigned k = 0; k < NUM_SLICES; k++) begin
      first_o[k]   = ((k & (span - 1)) == 0);
      last_o[k]    = ((k & (span - 1)) == (span - 1));
      top_idx_o[k] = IDX_W'(k | (span - 1));
    end
  end

endmodule

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);

  logic [W-1:0] b_eff;
  logic [W-1:0] low;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    low   = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, cin_i};
    cmsb_o = low[W-1];
    sum_o  = {a_i[W-1] ^ b_eff[W-1] ^ cmsb_o, low[W-2:0]};
    cout_o = (a_i[W-1] & b_eff[W-1]) | (cmsb_o & (a_i[W-1] ^ b_eff[W-1]));
  end

endmodule

// File: rtl/simd_sat_sel.sv
module simd_sat_sel #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] raw_i,
  input  logic         sat_i,
  input  logic         signed_i,
  input  logic         sub_i,
  input  logic         top_cout_i,
  input  logic         top_cmsb_i,
  input  logic         top_amsb_i,
  input  logic         is_top_i,
  output logic [W-1:0] res_o
);

  logic         u_ovf, s_ovf;
  logic [W-1:0] u_clamp, s_clamp;

  always_comb begin
    // unsigned sub: carry out low means borrow
    u_ovf   = sub_i ? ~top_cout_i : top_cout_i;
    s_ovf   = top_cout_i ^ top_cmsb_i;
    u_clamp = sub_i ? '0 : '1;
    // on signed overflow the true sign equals operand a's sign
    if (top_amsb_i) s_clamp = is_top_i ? {1'b1, {(W-1){1'b0}}} : '0;
    else            s_clamp = is_top_i ? {1'b0, {(W-1){1'b1}}} : '1;
    if (!sat_i)        res_o = raw_i;
    else if (signed_i) res_o = s_ovf ? s_clamp : raw_i;
    else               res_o = u_ovf ? u_clamp : raw_i;
  end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        lane_sel_i,
  input  logic              sub_i,
  input  logic              sat_i,
  input  logic              signed_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] result_o
);

  localparam int unsigned NUM_SLICES = DATA_W / SLICE_W;
  localparam int unsigned IDX_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

  lane_size_e              lane_size;
  logic [NUM_SLICES-1:0]   first_v, last_v;
  logic [IDX_W-1:0]        top_idx [NUM_SLICES];
  logic                    lane_ok;
  logic [NUM_SLICES-1:0]   cin_v, cout_v, cmsb_v, amsb_v;
  logic [DATA_W-1:0]       raw_sum, sat_sum, next_res;
  logic                    accept;
  logic                    valid_q;
  logic [DATA_W-1:0]       res_q;

  assign lane_size = lane_size_e'(lane_sel_i);
  assign accept    = valid_i & ready_i;
  assign ready_o   = ready_i;

  simd_lane_ctl #(
    .NUM_SLICES (NUM_SLICES),
    .IDX_W      (IDX_W)
  ) u_ctl (
    .lane_size_i (lane_size),
    .first_o     (first_v),
    .last_o      (last_v),
    .top_idx_o   (top_idx),
    .lane_ok_o   (lane_ok)
  );

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    if (k == 0) begin : g_head
      assign cin_v[k] = sub_i;
    end else begin : g_link
      // chain is cut where a lane starts
      assign cin_v[k] = first_v[k] ? sub_i : cout_v[k-1];
    end

    assign amsb_v[k] = a_i[k*SLICE_W + SLICE_W - 1];

    simd_slice_add #(.W(SLICE_W)) u_add (
      .a_i    (a_i[k*SLICE_W +: SLICE_W]),
      .b_i    (b_i[k*SLICE_W +: SLICE_W]),
      .sub_i  (sub_i),
      .cin_i  (cin_v[k]),
      .sum_o  (raw_sum[k*SLICE_W +: SLICE_W]),
      .cout_o (cout_v[k]),
      .cmsb_o (cmsb_v[k])
    );

    simd_sat_sel #(.W(SLICE_W)) u_sat (
      .raw_i      (raw_sum[k*SLICE_W +: SLICE_W]),
      .sat_i      (sat_i),
      .signed_i   (signed_i),
      .sub_i      (sub_i),
      .top_cout_i (cout_v[top_idx[k]]),
      .top_cmsb_i (cmsb_v[top_idx[k]]),
      .top_amsb_i (amsb_v[top_idx[k]]),
      .is_top_i   (last_v[k]),
      .res_o      (sat_sum[k*SLICE_W +: SLICE_W])
    );

    AST_USAT_ADD_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && lane_size == LANE_8 && sat_i && !signed_i && !sub_i)
      |=> (result_o[k*SLICE_W +: SLICE_W] >= $past(a_i[k*SLICE_W +: SLICE_W]))); // R5

    AST_SSAT_POS_STAYS_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && lane_size == LANE_8 && sat_i && signed_i && !sub_i
       && !a_i[k*SLICE_W + SLICE_W - 1] && !b_i[k*SLICE_W + SLICE_W - 1])
      |=> !result_o[k*SLICE_W + SLICE_W - 1]); // R6
  end

  assign next_res = lane_ok ? sat_sum : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (ready_i) begin
      valid_q <= valid_i;
      if (valid_i) res_q <= next_res;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> ($stable(result_o) && $stable(valid_o))); // R9

  AST_VALID_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> (valid_o == $past(valid_i))); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && lane_sel_i == 2'b11) |=> (result_o == '0)); // R8

  AST_LOW_LANE_WRAP_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !sat_i && !sub_i && lane_sel_i != 2'b11)
    |=> (result_o[SLICE_W-1:0] == $past(a_i[SLICE_W-1:0] + b_i[SLICE_W-1:0]))); // R2

  AST_LOW_LANE_WRAP_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !sat_i && sub_i && lane_sel_i != 2'b11)
    |=> (result_o[SLICE_W-1:0] == $past(a_i[SLICE_W-1:0] - b_i[SLICE_W-1:0]))); // R3

endmodule

// File: tb/simd_alu_test.sv
module simd_alu_test;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_RANDOM   = 4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [1:0]  lane_sel_i = '0;
  logic        sub_i = 1'b0, sat_i = 1'b0, signed_i = 1'b0;
  logic        ready_o, valid_o;
  logic [63:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic        exp_valid = 1'b0;
  logic [63:0] exp_res = '0;
  string       exp_tag = "R1";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  simd_alu uut (
    .clk_i, .rst_ni, .valid_i, .ready_o, .a_i, .b_i, .lane_sel_i,
    .sub_i, .sat_i, .signed_i, .valid_o, .ready_i, .result_o
  );

  function automatic logic [63:0] ref_alu(logic [63:0] a, logic [63:0] b, logic [1:0] lsel,
                                          logic sub, logic sat, logic sgn);
    logic [63:0] r;
    int w;
    longint mask, half, ua, ub, sa, sb, res;
    r = '0;
    if (lsel == 2'b11) return '0;
    w    = 8 << lsel;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    for (int l = 0; l < 64 / w; l++) begin
      ua  = longint'(a >> (l * w)) & mask;
      ub  = longint'(b >> (l * w)) & mask;
      sa  = (ua >= half) ? ua - (mask + 1) : ua;
      sb  = (ub >= half) ? ub - (mask + 1) : ub;
      res = sub ? ua - ub : ua + ub;
      if (sat && !sgn) begin
        if (res < 0) res = 0;
        else if (res > mask) res = mask;
      end else if (sat && sgn) begin
        res = sub ? sa - sb : sa + sb;
        if (res < -half) res = -half;
        else if (res > half - 1) res = half - 1;
      end
      r = r | ((64'(res) & 64'(mask)) << (l * w));
    end
    return r;
  endfunction

  function automatic string mode_tag(logic [1:0] lsel, logic sub, logic sat, logic sgn);
    if (lsel == 2'b11) return "R8";
    if (!sat && sgn)   return "R7";
    if (!sat)          return sub ? "R3" : "R2";
    if (!sgn)          return "R5";
    return "R6";
  endfunction

  function automatic logic [63:0] rand_op();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      case ($urandom % 6)
        0: v[i*8 +: 8] = 8'h00;
        1: v[i*8 +: 8] = 8'h7F;
        2: v[i*8 +: 8] = 8'h80;
        3: v[i*8 +: 8] = 8'hFF;
        default: v[i*8 +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge: check held outputs, drive, advance one cycle
  task automatic step(logic v, logic r, logic [63:0] a, logic [63:0] b, logic [1:0] lsel,
                      logic sub, logic sat, logic sgn, string tag);
    chk("R9 valid_o", 64'(valid_o), 64'(exp_valid));
    chk(exp_tag, result_o, exp_res);
    valid_i = v; ready_i = r; a_i = a; b_i = b;
    lane_sel_i = lsel; sub_i = sub; sat_i = sat; signed_i = sgn;
    #1;
    chk("R10 ready_o", 64'(ready_o), 64'(r));
    if (r) begin
      exp_valid = v;
      if (v) begin
        exp_res = ref_alu(a, b, lsel, sub, sat, sgn);
        exp_tag = (tag == "") ? mode_tag(lsel, sub, sat, sgn) : tag;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1 valid_o", 64'(valid_o), 64'd0);
    chk("R1 result_o", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // lane isolation, every width
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 0, 0, 0, "R4 add8");
    step(1, 1, 64'h00FF_00FF_FFFF_00FF, 64'h0001_0001_0001_0001, 2'b01, 0, 0, 0, "R4 add16");
    step(1, 1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'b10, 1, 0, 0, "R4 sub32");
    step(1, 1, 64'h0100_0000_0000_0000, 64'h0000_0000_0000_0001, 2'b00, 1, 0, 0, "R4 sub8");
    // unsigned saturation
    step(1, 1, 64'hF0F0_0000_FFFF_F000, 64'h2020_0000_0001_2000, 2'b00, 0, 1, 0, "R5 add8");
    step(1, 1, 64'h1010_0000_0000_0010, 64'h2020_0000_0001_0020, 2'b01, 1, 1, 0, "R5 sub16");
    step(1, 1, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0009, 2'b10, 0, 1, 0, "R5 add32");
    // signed saturation
    step(1, 1, 64'h7F80_7F80_0102_FF00, 64'h0101_8001_7F7F_8080, 2'b00, 0, 1, 1, "R6 add8");
    step(1, 1, 64'h8000_7FFF_0001_FFFF, 64'h0001_FFFF_0002_7FFF, 2'b01, 1, 1, 1, "R6 sub16");
    step(1, 1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 2'b10, 0, 1, 1, "R6 add32");
    // signed select ignored in wrap mode
    step(1, 1, 64'h7F80_7F80_FFFF_0000, 64'h0101_8001_0001_0001, 2'b00, 0, 0, 1, "R7 add8");
    step(1, 1, 64'h8000_0000_7FFF_FFFF, 64'h0001_0000_FFFF_FFFF, 2'b01, 1, 0, 1, "R7 sub16");
    // reserved lane code
    step(1, 1, 64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444, 2'b11, 0, 1, 1, "R8 rsvd");
    // stall holds, bubble clears valid
    step(1, 0, 64'h1234_5678_9ABC_DEF0, 64'h1, 2'b00, 0, 0, 0, "R9 stall");
    step(1, 0, 64'hFFFF_0000_FFFF_0000, 64'h2, 2'b01, 1, 1, 0, "R9 stall");
    step(0, 1, 64'h5555_5555_5555_5555, 64'h3, 2'b10, 0, 0, 0, "R9 bubble");
    step(1, 1, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 2'b00, 0, 0, 0, "R2 add8");

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [1:0] lsel;
      lsel = (($urandom % 16) == 0) ? 2'b11 : 2'($urandom % 3);
      step(($urandom % 5) != 0, ($urandom % 5) != 0, rand_op(), rand_op(), lsel,
           1'($urandom), 1'($urandom), 1'($urandom), "");
    end
    step(0, 1, '0, '0, 2'b00, 0, 0, 0, "R9 drain");
    step(0, 1, '0, '0, 2'b00, 0, 0, 0, "R9 drain");
    finish_run();
  end

endmodule